// File: doc/BRIEF.md
# GPIO Edge Capture and Interrupt Unit

This block watches 128 general-purpose pin levels, grouped as four banks of 32, and records the level transitions that software has asked for. Every pin has two enable bits: one arms capture of low-to-high changes, the other arms capture of high-to-low changes. A captured change sets a sticky bit in the bank's status register. Software reads the bank's status register, then writes ones to clear the bits it has handled. Capture only applies to pins that the direction input marks as inputs.

The status bits feed three interrupt lines. One follows pin 0 alone, one follows pin 1 alone, and the third is raised by any other pin. While the processor reports that it is halted, a change on an input pin that belongs to a fixed set of wake sources raises a one-cycle wake request. Pin levels arrive asynchronously and are brought into the clock domain inside the block. Pins whose index is at or above the configured line count never take part.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, every enable bit and every status bit is 0, and irq_pin0, irq_pin1, irq_other and wake_req are all 0.
- R2: With its rising-enable bit set (rising-enable registers at byte offsets 0x030, 0x034, 0x038 and 0x130 for banks 0 to 3), an input pin that goes from 0 to 1 sets its status bit. The status bit is visible two clock edges after the edge that first samples the new level. Status registers are at 0x048, 0x04C, 0x050 and 0x148, and bit i of a bank is pin 32*bank+i.
- R3: With its falling-enable bit set (falling-enable registers at 0x03C, 0x040, 0x044 and 0x13C), an input pin that goes from 1 to 0 sets its status bit. With neither enable set, no change sets a status bit.
- R4: A pin whose pin_dir bit is 1 (an output) never sets its status bit, whatever its enables.
- R5: Writing a status register clears each bit written as 1 and leaves each bit written as 0 unchanged. Enable registers read back the value last written.
- R6: If a new edge on a pin and a write-1-to-clear of that pin's status bit fall in the same cycle, the bit ends up set.
- R7: irq_pin0 equals bank 0 status bit 0 and irq_pin1 equals bank 0 status bit 1. irq_other is the OR of bank 0 bits 31..2 and all bits of banks 1 to 3. Each output lags the status register by one clock.
- R8: While cpu_halted is 1, any change on an input pin set in the wake-source mask pulses wake_req high for one cycle, in the same cycle that a status bit would be set. The masks are 0x8003FE1B, 0x002001FC, 0xEC080000 and 0x0012007F for banks 0 to 3. Changes on pins outside the mask, on output pins, or while cpu_halted is 0 do not raise it.
- R9: Pins with index NUM_LINES or above (default 121) never set a status bit and never raise wake_req.
- R10: No change is detected until the synchronizer and the previous-sample register hold post-reset samples, so a pin already high at reset raises neither a status bit nor wake_req.
- R11: Reads of any undecoded offset return 0, and writes to undecoded offsets change nothing. Read data appears on reg_rdata one clock after reg_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | 128 | Asynchronous pin levels, bit 32*bank+i is pin i of a bank |
| pin_dir | input | 128 | Direction per pin, 1 = output (edge capture blocked) |
| cpu_halted | input | 1 | Processor halted; enables wake requests |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 9 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| irq_pin0 | output | 1 | Interrupt for pin 0 |
| irq_pin1 | output | 1 | Interrupt for pin 1 |
| irq_other | output | 1 | Interrupt for all other pins |
| wake_req | output | 1 | One-cycle wake pulse |

## Verification
A pin change driven just before clock edge k reaches the second synchronizer stage at k+1. It is compared with the previous sample in that cycle, so the status bit and wake_req change at k+2 and the interrupt outputs at k+3. The bench drives on falling edges and counts falling edges from the change. It samples wake_req and the interrupts in the exact half-cycle where they are due and also checks that they are still low one half-cycle earlier. The same-cycle clear is timed so that its write strobe lands on edge k+2. Register reads are sampled on the falling edge after the edge that registers them.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int NUM_BANKS = 4;
    localparam int BANK_W    = 32;
    localparam int ADDR_W    = 9;
    localparam int DATA_W    = 32;

    localparam logic [ADDR_W-1:0] RISE_BASE = 9'h030;
    localparam logic [ADDR_W-1:0] FALL_BASE = 9'h03C;
    localparam logic [ADDR_W-1:0] STAT_BASE = 9'h048;
    localparam logic [ADDR_W-1:0] HIGH_STEP = 9'h100;

    typedef enum logic [1:0] {
        REG_NONE,
        REG_RISE,
        REG_FALL,
        REG_STAT
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [1:0] bank;
    } reg_sel_t;

    typedef struct packed {
        logic wr_rise;
        logic wr_fall;
        logic wr_clr;
    } bank_wr_t;

    // last bank sits one page above its base, the others are word-spaced
    function automatic logic [ADDR_W-1:0] reg_addr_of(logic [ADDR_W-1:0] base, int bank);
        if (bank == NUM_BANKS - 1)
            return base + HIGH_STEP;
        return base + ADDR_W'(4 * bank);
    endfunction

    function automatic reg_sel_t decode_addr(logic [ADDR_W-1:0] addr);
        reg_sel_t sel;
        sel.kind = REG_NONE;
        sel.bank = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (addr == reg_addr_of(RISE_BASE, b)) begin
                sel.kind = REG_RISE;
                sel.bank = 2'(b);
            end
            if (addr == reg_addr_of(FALL_BASE, b)) begin
                sel.kind = REG_FALL;
                sel.bank = 2'(b);
            end
            if (addr == reg_addr_of(STAT_BASE, b)) begin
                sel.kind = REG_STAT;
                sel.bank = 2'(b);
            end
        end
        return sel;
    endfunction

    function automatic logic [BANK_W-1:0] wake_src(int bank);
        case (bank)
            0:       return 32'h8003FE1B;
            1:       return 32'h002001FC;
            2:       return 32'hEC080000;
            3:       return 32'h0012007F;
            default: return '0;
        endcase
    endfunction

    function automatic logic [BANK_W-1:0] line_mask(int bank, int nlines);
        logic [BANK_W-1:0] m;
        for (int i = 0; i < BANK_W; i++)
            m[i] = ((bank * BANK_W + i) < nlines);
        return m;
    endfunction

endpackage

// File: rtl/gpio_pin_sampler.sv
module gpio_pin_sampler #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_async,
    output logic [W-1:0] pin_cur,
    output logic [W-1:0] pin_prev,
    output logic         armed
);
    logic [W-1:0] stage1;
    logic [1:0]   fill_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1   <= '0;
            pin_cur  <= '0;
            pin_prev <= '0;
            fill_cnt <= '0;
        end else begin
            stage1   <= pin_async;
            pin_cur  <= stage1;
            pin_prev <= pin_cur;
            if (fill_cnt != 2'd3)
                fill_cnt <= fill_cnt + 2'd1;
        end
    end

    // pin_prev holds a post-reset sample once three edges have passed
    assign armed = (fill_cnt == 2'd3);

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
    import gpio_edge_pkg::*;
#(
    parameter int BANK_IDX  = 0,
    parameter int NUM_LINES = 121
) (
    input  logic              clk,
    input  logic              rst,
    input  bank_wr_t          wr,
    input  logic [BANK_W-1:0] wdata,
    input  logic [BANK_W-1:0] pin_cur,
    input  logic [BANK_W-1:0] pin_prev,
    input  logic [BANK_W-1:0] dir,
    input  logic              armed,
    output logic [BANK_W-1:0] rise_en,
    output logic [BANK_W-1:0] fall_en,
    output logic [BANK_W-1:0] status,
    output logic              wake_hit
);
    localparam logic [BANK_W-1:0] LIVE_LINES = line_mask(BANK_IDX, NUM_LINES);
    localparam logic [BANK_W-1:0] WAKE_MASK  = wake_src(BANK_IDX);

    logic [BANK_W-1:0] live;
    logic [BANK_W-1:0] rise_ev;
    logic [BANK_W-1:0] fall_ev;
    logic [BANK_W-1:0] clr_bits;
    logic [BANK_W-1:0] status_d;

    always_comb begin
        live     = ~dir & LIVE_LINES & {BANK_W{armed}};
        rise_ev  = pin_cur & ~pin_prev & rise_en & live;
        fall_ev  = ~pin_cur & pin_prev & fall_en & live;
        clr_bits = wr.wr_clr ? wdata : '0;
        // new events are ORed in after the clear so they win
        status_d = (status & ~clr_bits) | rise_ev | fall_ev;
        wake_hit = |((pin_cur ^ pin_prev) & live & WAKE_MASK);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rise_en <= '0;
            fall_en <= '0;
            status  <= '0;
        end else begin
            if (wr.wr_rise) rise_en <= wdata;
            if (wr.wr_fall) fall_en <= wdata;
            status <= status_d;
        end
    end

endmodule

// File: rtl/gpio_irq_combine.sv
module gpio_irq_combine #(
    parameter int TOTAL = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TOTAL-1:0] status_flat,
    input  logic             wake_any,
    input  logic             cpu_halted,
    output logic             irq_pin0,
    output logic             irq_pin1,
    output logic             irq_other,
    output logic             wake_req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_pin0  <= 1'b0;
            irq_pin1  <= 1'b0;
            irq_other <= 1'b0;
            wake_req  <= 1'b0;
        end else begin
            irq_pin0  <= status_flat[0];
            irq_pin1  <= status_flat[1];
            irq_other <= |status_flat[TOTAL-1:2];
            wake_req  <= cpu_halted & wake_any;
        end
    end

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
    import gpio_edge_pkg::*;
#(
    parameter int NUM_LINES = 121
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_BANKS*BANK_W-1:0] pin_in,
    input  logic [NUM_BANKS*BANK_W-1:0] pin_dir,
    input  logic                        cpu_halted,
    input  logic                        reg_wr,
    input  logic                        reg_rd,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [DATA_W-1:0]           reg_wdata,
    output logic [DATA_W-1:0]           reg_rdata,
    output logic                        irq_pin0,
    output logic                        irq_pin1,
    output logic                        irq_other,
    output logic                        wake_req
);
    localparam int TOTAL_PINS = NUM_BANKS * BANK_W;

    logic [TOTAL_PINS-1:0] pin_cur;
    logic [TOTAL_PINS-1:0] pin_prev;
    logic                  armed;
    logic [TOTAL_PINS-1:0] status_flat;
    logic [BANK_W-1:0]     rise_arr [NUM_BANKS];
    logic [BANK_W-1:0]     fall_arr [NUM_BANKS];
    logic [BANK_W-1:0]     stat_arr [NUM_BANKS];
    logic [NUM_BANKS-1:0]  wake_hits;
    reg_sel_t              sel;
    logic [DATA_W-1:0]     rd_val;

    assign sel = decode_addr(reg_addr);

    gpio_pin_sampler #(.W(TOTAL_PINS)) u_sampler (
        .clk       (clk),
        .rst       (rst),
        .pin_async (pin_in),
        .pin_cur   (pin_cur),
        .pin_prev  (pin_prev),
        .armed     (armed)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_wr_t wr_b;

        assign wr_b.wr_rise = reg_wr && (sel.kind == REG_RISE) && (sel.bank == 2'(b));
        assign wr_b.wr_fall = reg_wr && (sel.kind == REG_FALL) && (sel.bank == 2'(b));
        assign wr_b.wr_clr  = reg_wr && (sel.kind == REG_STAT) && (sel.bank == 2'(b));

        gpio_edge_bank #(
            .BANK_IDX  (b),
            .NUM_LINES (NUM_LINES)
        ) u_bank (
            .clk      (clk),
            .rst      (rst),
            .wr       (wr_b),
            .wdata    (reg_wdata),
            .pin_cur  (pin_cur[b*BANK_W +: BANK_W]),
            .pin_prev (pin_prev[b*BANK_W +: BANK_W]),
            .dir      (pin_dir[b*BANK_W +: BANK_W]),
            .armed    (armed),
            .rise_en  (rise_arr[b]),
            .fall_en  (fall_arr[b]),
            .status   (stat_arr[b]),
            .wake_hit (wake_hits[b])
        );

        assign status_flat[b*BANK_W +: BANK_W] = stat_arr[b];
    end

    gpio_irq_combine #(.TOTAL(TOTAL_PINS)) u_combine (
        .clk         (clk),
        .rst         (rst),
        .status_flat (status_flat),
        .wake_any    (|wake_hits),
        .cpu_halted  (cpu_halted),
        .irq_pin0    (irq_pin0),
        .irq_pin1    (irq_pin1),
        .irq_other   (irq_other),
        .wake_req    (wake_req)
    );

    always_comb begin
        case (sel.kind)
            REG_RISE: rd_val = rise_arr[sel.bank];
            REG_FALL: rd_val = fall_arr[sel.bank];
            REG_STAT: rd_val = stat_arr[sel.bank];
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            reg_rdata <= '0;
        else
            reg_rdata <= reg_rd ? rd_val : '0;
    end

endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
    parameter int TOTAL     = 128,
    parameter int NUM_LINES = 121
) (
    input logic             clk,
    input logic             rst,
    input logic [TOTAL-1:0] status_flat,
    input logic [TOTAL-1:0] pin_dir,
    input logic             cpu_halted,
    input logic             irq_pin0,
    input logic             irq_pin1,
    input logic             irq_other,
    input logic             wake_req
);
    // R7
    irq_pin0_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_pin0 == $past(status_flat[0])));

    // R7
    irq_pin1_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_pin1 == $past(status_flat[1])));

    // R7
    irq_other_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_other == $past(|status_flat[TOTAL-1:2])));

    // R8
    wake_needs_halt_chk: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> $past(cpu_halted));

    // R4
    no_output_capture_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_flat & ~$past(status_flat) & $past(pin_dir)) == '0));

    if (NUM_LINES < TOTAL) begin : g_unused_lines
        // R9
        unused_lines_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            status_flat[TOTAL-1:NUM_LINES] == '0);
    end

endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(
    .TOTAL     (TOTAL_PINS),
    .NUM_LINES (NUM_LINES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .status_flat (status_flat),
    .pin_dir     (pin_dir),
    .cpu_halted  (cpu_halted),
    .irq_pin0    (irq_pin0),
    .irq_pin1    (irq_pin1),
    .irq_other   (irq_other),
    .wake_req    (wake_req)
);

// File: tb/gpio_edge_irq_tb.sv
module gpio_edge_irq_tb;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [127:0] pin_in = '0;
    logic [127:0] pin_dir = '0;
    logic         cpu_halted = 1'b0;
    logic         reg_wr = 1'b0;
    logic         reg_rd = 1'b0;
    logic [8:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         irq_pin0, irq_pin1, irq_other, wake_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    gpio_edge_irq u_dut (
        .clk        (clk),
        .rst        (rst),
        .pin_in     (pin_in),
        .pin_dir    (pin_dir),
        .cpu_halted (cpu_halted),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_pin0   (irq_pin0),
        .irq_pin1   (irq_pin1),
        .irq_other  (irq_other),
        .wake_req   (wake_req)
    );

    localparam logic [8:0] RISE_A [4] = '{9'h030, 9'h034, 9'h038, 9'h130};
    localparam logic [8:0] FALL_A [4] = '{9'h03C, 9'h040, 9'h044, 9'h13C};
    localparam logic [8:0] STAT_A [4] = '{9'h048, 9'h04C, 9'h050, 9'h148};

    // {bank, rise, fall, dir, level before, level after, expected status}
    localparam int NV = 6;
    localparam logic [223:0] VECS [NV] = '{
        {32'd0, 32'hFFFFFFFF, 32'h00000000, 32'h00000000, 32'h00000000, 32'h000000F3, 32'h000000F3},
        {32'd1, 32'h00000000, 32'hFFFF0000, 32'h00000000, 32'hFFFFFFFF, 32'h0000FFFF, 32'hFFFF0000},
        {32'd2, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0000FFFF, 32'h00FF00FF, 32'hFF00FF00, 32'hFFFF0000},
        {32'd3, 32'hFFFFFFFF, 32'h00000000, 32'h00000000, 32'h00000000, 32'hFFFFFFFF, 32'h01FFFFFF},
        {32'd0, 32'h0000000F, 32'h000000F0, 32'h00000000, 32'h000000F0, 32'h0000000F, 32'h000000FF},
        {32'd1, 32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000, 32'hFFFFFFFF, 32'h00000000}
    };
    localparam string VTAG [NV] = '{"R2", "R3", "R4", "R9", "R2 R3", "R3"};

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(logic [8:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [8:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic clear_all();
        for (int b = 0; b < 4; b++) wr(STAT_A[b], 32'hFFFFFFFF);
        tick(2);
    endtask

    // counts wake pulses over 6 half-cycles after a pin change; reports first
    task automatic wake_probe(output int cnt, output int first);
        cnt = 0; first = 0;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            if (wake_req) begin
                cnt++;
                if (first == 0) first = i;
            end
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        int cnt, first;

        // pin 0 high and halted across reset: must not look like a change (R10)
        pin_in[0] = 1'b1;
        cpu_halted = 1'b1;
        tick(4);
        rst = 1'b0;
        check("R1 irq_pin0", {31'd0, irq_pin0}, 32'd0);
        check("R1 irq_other", {31'd0, irq_other}, 32'd0);
        cnt = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (wake_req) cnt++;
        end
        check("R10 no wake after reset", cnt, 0);
        cpu_halted = 1'b0;
        rd(RISE_A[0], d); check("R1 rise reset", d, 32'd0);
        rd(FALL_A[3], d); check("R1 fall reset", d, 32'd0);
        rd(STAT_A[0], d); check("R1 status reset", d, 32'd0);

        // undecoded offsets (R11)
        wr(9'h100, 32'hFFFFFFFF);
        rd(9'h100, d); check("R11 undecoded read", d, 32'd0);
        rd(RISE_A[3], d); check("R11 no side write", d, 32'd0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            int b;
            logic [31:0] re, fe, dr, p0, p1, ex;
            logic e0, e1, ex_o;
            b  = int'(VECS[v][223:192]);
            re = VECS[v][191:160]; fe = VECS[v][159:128]; dr = VECS[v][127:96];
            p0 = VECS[v][95:64];   p1 = VECS[v][63:32];   ex = VECS[v][31:0];
            pin_dir[b*32 +: 32] = dr;
            pin_in[b*32 +: 32]  = p0;
            tick(6);
            wr(RISE_A[b], re);
            wr(FALL_A[b], fe);
            clear_all();
            rd(RISE_A[b], d); check("R5 rise readback", d, re);
            pin_in[b*32 +: 32] = p1;
            tick(6);
            rd(STAT_A[b], d); check(VTAG[v], d, ex);
            e0   = (b == 0) && ex[0];
            e1   = (b == 0) && ex[1];
            ex_o = (b == 0) ? (|ex[31:2]) : (|ex);
            check("R7 irq_pin0", {31'd0, irq_pin0}, {31'd0, e0});
            check("R7 irq_pin1", {31'd0, irq_pin1}, {31'd0, e1});
            check("R7 irq_other", {31'd0, irq_other}, {31'd0, ex_o});
            wr(RISE_A[b], 32'd0);
            wr(FALL_A[b], 32'd0);
            pin_dir[b*32 +: 32] = '0;
        end

        // interrupt latency on pin 1 (R7, R2)
        pin_in[31:0] = '0;
        tick(6);
        clear_all();
        wr(RISE_A[0], 32'h2);
        pin_in[1] = 1'b1;
        tick(3);
        check("R2 status due at k+2 irq not yet", {31'd0, irq_pin1}, 32'd0);
        tick(1);
        check("R7 irq_pin1 at k+3", {31'd0, irq_pin1}, 32'd1);

        // write-one-to-clear (R5)
        wr(STAT_A[0], 32'h0);
        rd(STAT_A[0], d); check("R5 zero write keeps", d, 32'h2);
        wr(STAT_A[0], 32'h2);
        rd(STAT_A[0], d); check("R5 one write clears", d, 32'h0);
        check("R5 irq_pin1 dropped", {31'd0, irq_pin1}, 32'd0);

        // same-cycle edge and clear (R6)
        wr(RISE_A[0], 32'h20);
        pin_in[5] = 1'b1;
        tick(2);
        wr(STAT_A[0], 32'h20);
        rd(STAT_A[0], d); check("R6 event beats clear", d, 32'h20);
        wr(RISE_A[0], 32'h0);
        clear_all();

        // wake requests (R8)
        pin_in[31:0] = '0;
        pin_in[127:96] = '0;
        pin_in[95:64] = '0;
        tick(6);
        cpu_halted = 1'b1;
        pin_in[0] = 1'b1;
        wake_probe(cnt, first);
        check("R8 wake pulse count pin0", cnt, 1);
        check("R8 wake timing pin0", first, 3);
        pin_in[2] = 1'b1;
        wake_probe(cnt, first);
        check("R8 pin outside mask", cnt, 0);
        pin_in[95] = 1'b1;
        wake_probe(cnt, first);
        check("R8 bank2 pin31 wakes", cnt, 1);
        pin_dir[0] = 1'b1;
        pin_in[0] = 1'b0;
        wake_probe(cnt, first);
        check("R8 output pin no wake", cnt, 0);
        pin_dir[0] = 1'b0;
        cpu_halted = 1'b0;
        pin_in[0] = 1'b1;
        wake_probe(cnt, first);
        check("R8 not halted no wake", cnt, 0);

        // line beyond count never wakes or captures (R9)
        cpu_halted = 1'b1;
        wr(RISE_A[3], 32'hFFFFFFFF);
        clear_all();
        pin_in[127] = 1'b1;
        wake_probe(cnt, first);
        check("R9 high line no wake", cnt, 0);
        rd(STAT_A[3], d); check("R9 high line no capture", d, 32'd0);
        cpu_halted = 1'b0;

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule